// File: doc/BRIEF.md
# D-PHY Data Lane Burst Sequencer

This block steps one high-speed transmit data lane through the low-power handshake that opens and closes every burst. A burst request moves the lane from its stop level through the two low-power entry levels and then into high-speed mode. The block then emits a zero preamble and streams the payload bytes from a valid/ready source. After the payload it drives the trail pattern, returns to stop, and holds stop for an exit guard time. Each phase length is a whole number of byte-clock cycles. The lengths come from two configuration words, which arrive as plain input ports.

The outputs feed an analog front end. Two single-ended low-power line levels drive the low-power drivers. A high-speed enable and one byte per cycle go to the serializer. The entry levels are produced by a counter-driven state machine. The machine always holds each level for its full programmed count, including on the first burst after reset, so a receiver never sees a truncated start-of-transmission.

Top module: `dphy_lane_seq`

## Requirements
- R1: During and right after reset the lane is in stop state. `lp_line_o` is 2'b11, where bit 1 is the positive line and bit 0 the negative line. `hs_en_o`, `busy_o` and `tx_ready_o` are all 0.
- R2: Every burst, including the first one after reset, goes LP-11, then LP-01 (`lp_line_o`=2'b01), then LP-00 (2'b00 with `hs_en_o` low), then HS-0, then payload. No level is skipped. While `hs_en_o` is high, `lp_line_o` is 2'b00.
- R3: LP-01 lasts exactly the low-power length field, `gen_timing_i[15:8]`, in cycles.
- R4: LP-00 lasts exactly the prepare field, `lane_timing_i[7:0]`, in cycles. HS-0 then lasts exactly the zero field, `lane_timing_i[15:8]`, in cycles, with `hs_en_o` high and `hs_data_o` all zeros.
- R5: `tx_ready_o` is high only in the payload phase. In a cycle where `tx_valid_i` is high there, `hs_data_o` equals `tx_data_i`. In a payload cycle without valid, the previous payload byte is repeated, or zero if no byte was taken yet. A handshake with `tx_last_i` high ends the payload.
- R6: After the final byte, the trail lasts exactly the trail field, `lane_timing_i[23:16]`, in cycles. During the trail, `hs_en_o` is high and every bit of `hs_data_o` is the inverse of bit 7 of the final byte.
- R7: After the trail the lane returns to 2'b11 with `busy_o` high for exactly the exit field, `gen_timing_i[7:0]`, in cycles. No new burst can start during that hold.
- R8: A timing field of zero gives a phase of one cycle.
- R9: Both configuration words are sampled when a request is accepted. Changes during a burst affect only later bursts.
- R10: Bits 31:24 of `lane_timing_i` and bits 31:16 of `gen_timing_i` have no effect.
- R11: `busy_o` is high from the cycle after acceptance until the exit hold ends. A request raised while busy is kept, and its burst starts after one idle stop cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| burst_req_i | input | 1 | Burst request (level or pulse) |
| tx_data_i | input | 8 | Payload byte |
| tx_valid_i | input | 1 | Payload byte valid |
| tx_last_i | input | 1 | Marks the final payload byte |
| tx_ready_o | output | 1 | Payload byte taken this cycle if valid |
| lane_timing_i | input | 32 | Prepare [7:0], zero [15:8], trail [23:16] |
| gen_timing_i | input | 32 | Exit [7:0], low-power length [15:8] |
| lp_line_o | output | 2 | Low-power levels: bit 1 positive, bit 0 negative |
| hs_en_o | output | 1 | High-speed drive enable |
| hs_data_o | output | 8 | Byte to the serializer |
| busy_o | output | 1 | Burst in progress, including the exit hold |

## Verification
The bench uses the default build: 8-bit timing fields inside 32-bit words, 8-bit bytes, and the final bit taken as bit 7. Field values 0 to 10 keep every phase short, so one run covers dozens of bursts. That range reaches the zero-field clamp, single-byte payloads and stalled payload cycles. It also reaches a request queued mid-burst and configuration rewrites during a burst, each within a few hundred cycles.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_LP01  = 3'd1,
      ST_LP00  = 3'd2,
      ST_HSZ   = 3'd3,
      ST_PAY   = 3'd4,
      ST_TRAIL = 3'd5,
      ST_EXIT  = 3'd6
   } lane_st_e;

   localparam int unsigned NUM_FLD   = 5;
   localparam int unsigned FLD_LPX   = 0;
   localparam int unsigned FLD_PREP  = 1;
   localparam int unsigned FLD_ZERO  = 2;
   localparam int unsigned FLD_TRAIL = 3;
   localparam int unsigned FLD_EXIT  = 4;

   // true when the field lives in the general word, false for the lane word
   function automatic bit fld_in_gen(input int unsigned idx);
      return (idx == FLD_LPX) || (idx == FLD_EXIT);
   endfunction

   // slot of the field inside its word, in units of the field width
   function automatic int unsigned fld_slot(input int unsigned idx);
      case (idx)
         FLD_LPX:   return 1;
         FLD_PREP:  return 0;
         FLD_ZERO:  return 1;
         FLD_TRAIL: return 2;
         default:   return 0;
      endcase
   endfunction

endpackage

// File: rtl/dphy_seq_cfg.sv
module dphy_seq_cfg
   import dphy_seq_pkg::*;
#(
   parameter int unsigned FLD_W  = 8,
   parameter int unsigned WORD_W = 32
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              cap_i,
   input  logic [WORD_W-1:0]                 lane_word_i,
   input  logic [WORD_W-1:0]                 gen_word_i,
   output logic [NUM_FLD-1:0][FLD_W-1:0]     live_o,
   output logic [NUM_FLD-1:0][FLD_W-1:0]     held_o
);

   localparam int unsigned LANE_USED = 3 * FLD_W;
   localparam int unsigned GEN_USED  = 2 * FLD_W;
   localparam logic [FLD_W-1:0] ONE  = FLD_W'(1);

   for (genvar g = 0; g < NUM_FLD; g++) begin : g_fld
      localparam int unsigned OFS = fld_slot(g) * FLD_W;
      logic [FLD_W-1:0] raw;
      if (fld_in_gen(g)) begin : g_gen
         assign raw = gen_word_i[OFS +: FLD_W];
      end else begin : g_lane
         assign raw = lane_word_i[OFS +: FLD_W];
      end
      // a zero count still yields one cycle
      assign live_o[g] = (raw == '0) ? ONE : raw;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            held_o[g] <= ONE;
         end else if (cap_i) begin
            held_o[g] <= live_o[g];
         end
      end
   end

   if (WORD_W > LANE_USED) begin : g_lane_spare
      logic unused_lane_hi;
      assign unused_lane_hi = ^lane_word_i[WORD_W-1:LANE_USED];
   end
   if (WORD_W > GEN_USED) begin : g_gen_spare
      logic unused_gen_hi;
      assign unused_gen_hi = ^gen_word_i[WORD_W-1:GEN_USED];
   end

endmodule

// File: rtl/dphy_seq_timer.sv
module dphy_seq_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             done_o
);

   logic [CNT_W-1:0] cnt_q;

   // len_i is never zero, so len_i - 1 cycles remain after the load cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= len_i - CNT_W'(1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/dphy_seq_fsm.sv
module dphy_seq_fsm
   import dphy_seq_pkg::*;
#(
   parameter int unsigned FLD_W = 8
) (
   input  logic                          clk_i,
   input  logic                          rst_ni,
   input  logic                          req_i,
   input  logic                          valid_i,
   input  logic                          last_i,
   input  logic                          done_i,
   input  logic [FLD_W-1:0]              live_lpx_i,
   input  logic [NUM_FLD-1:0][FLD_W-1:0] held_i,
   output lane_st_e                      state_o,
   output logic                          accept_o,
   output logic                          load_o,
   output logic [FLD_W-1:0]              len_o
);

   lane_st_e state_q, state_d;
   logic     pend_q;
   logic [FLD_W-1:0] unused_held_lpx;

   assign unused_held_lpx = held_i[FLD_LPX];

   always_comb begin
      state_d  = state_q;
      accept_o = 1'b0;
      load_o   = 1'b0;
      len_o    = '0;
      unique case (state_q)
         ST_IDLE: if (req_i || pend_q) begin
            state_d  = ST_LP01;
            accept_o = 1'b1;
            load_o   = 1'b1;
            len_o    = live_lpx_i;
         end
         ST_LP01: if (done_i) begin
            state_d = ST_LP00;
            load_o  = 1'b1;
            len_o   = held_i[FLD_PREP];
         end
         ST_LP00: if (done_i) begin
            state_d = ST_HSZ;
            load_o  = 1'b1;
            len_o   = held_i[FLD_ZERO];
         end
         ST_HSZ: if (done_i) begin
            state_d = ST_PAY;
         end
         ST_PAY: if (valid_i && last_i) begin
            state_d = ST_TRAIL;
            load_o  = 1'b1;
            len_o   = held_i[FLD_TRAIL];
         end
         ST_TRAIL: if (done_i) begin
            state_d = ST_EXIT;
            load_o  = 1'b1;
            len_o   = held_i[FLD_EXIT];
         end
         ST_EXIT: if (done_i) begin
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= accept_o ? 1'b0 : (pend_q | req_i);
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/dphy_seq_hsdata.sv
module dphy_seq_hsdata
   import dphy_seq_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter bit          MSB_LAST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  lane_st_e          state_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              valid_i,
   output logic [DATA_W-1:0] hs_data_o
);

   logic [DATA_W-1:0] last_q;
   logic              final_bit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         last_q <= '0;
      end else if (state_i == ST_HSZ) begin
         last_q <= '0;
      end else if (state_i == ST_PAY && valid_i) begin
         last_q <= data_i;
      end
   end

   if (MSB_LAST) begin : g_msb
      assign final_bit = last_q[DATA_W-1];
   end else begin : g_lsb
      assign final_bit = last_q[0];
   end

   always_comb begin
      unique case (state_i)
         ST_PAY:   hs_data_o = valid_i ? data_i : last_q;
         ST_TRAIL: hs_data_o = {DATA_W{~final_bit}};
         default:  hs_data_o = '0;
      endcase
   end

endmodule

// File: rtl/dphy_lane_seq.sv
module dphy_lane_seq
   import dphy_seq_pkg::*;
#(
   parameter int unsigned FLD_W    = 8,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned DATA_W   = 8,
   parameter bit          MSB_LAST = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              burst_req_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic              tx_valid_i,
   input  logic              tx_last_i,
   output logic              tx_ready_o,
   input  logic [WORD_W-1:0] lane_timing_i,
   input  logic [WORD_W-1:0] gen_timing_i,
   output logic [1:0]        lp_line_o,
   output logic              hs_en_o,
   output logic [DATA_W-1:0] hs_data_o,
   output logic              busy_o
);

   if (FLD_W < 1) begin : g_bad_fld
      $error("FLD_W must be at least 1");
   end
   if (WORD_W < 3 * FLD_W) begin : g_bad_word
      $error("WORD_W must hold three timing fields");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   lane_st_e                      state;
   logic                          accept, load, done;
   logic [FLD_W-1:0]              len;
   logic [NUM_FLD-1:0][FLD_W-1:0] live, held;

   dphy_seq_cfg #(.FLD_W(FLD_W), .WORD_W(WORD_W)) u_cfg (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cap_i       (accept),
      .lane_word_i (lane_timing_i),
      .gen_word_i  (gen_timing_i),
      .live_o      (live),
      .held_o      (held)
   );

   dphy_seq_fsm #(.FLD_W(FLD_W)) u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (burst_req_i),
      .valid_i    (tx_valid_i),
      .last_i     (tx_last_i),
      .done_i     (done),
      .live_lpx_i (live[FLD_LPX]),
      .held_i     (held),
      .state_o    (state),
      .accept_o   (accept),
      .load_o     (load),
      .len_o      (len)
   );

   dphy_seq_timer #(.CNT_W(FLD_W)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load),
      .len_i  (len),
      .done_o (done)
   );

   dphy_seq_hsdata #(.DATA_W(DATA_W), .MSB_LAST(MSB_LAST)) u_hsdata (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .state_i   (state),
      .data_i    (tx_data_i),
      .valid_i   (tx_valid_i),
      .hs_data_o (hs_data_o)
   );

   always_comb begin
      unique case (state)
         ST_IDLE, ST_EXIT: lp_line_o = 2'b11;
         ST_LP01:          lp_line_o = 2'b01;
         default:          lp_line_o = 2'b00;
      endcase
   end

   assign hs_en_o    = (state == ST_HSZ) || (state == ST_PAY) || (state == ST_TRAIL);
   assign tx_ready_o = (state == ST_PAY);
   assign busy_o     = (state != ST_IDLE);

endmodule

// File: rtl/dphy_lane_seq_chk.sv
module dphy_lane_seq_chk #(
   parameter int unsigned FLD_W    = 8,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned DATA_W   = 8,
   parameter bit          MSB_LAST = 1'b1
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              burst_req_i,
   input logic [DATA_W-1:0] tx_data_i,
   input logic              tx_valid_i,
   input logic              tx_last_i,
   input logic              tx_ready_o,
   input logic [WORD_W-1:0] lane_timing_i,
   input logic [WORD_W-1:0] gen_timing_i,
   input logic [1:0]        lp_line_o,
   input logic              hs_en_o,
   input logic [DATA_W-1:0] hs_data_o,
   input logic              busy_o
);

   // R2: high-speed drive only with both low-power lines low
   p_hs_lines_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hs_en_o |-> (lp_line_o == 2'b00));

   // R2: LP-01 can only persist or move on to LP-00
   p_lp01_next_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lp_line_o == 2'b01) |=> (lp_line_o == 2'b01) || (lp_line_o == 2'b00 && !hs_en_o));

   // R2: LP-01 is only entered from stop
   p_lp01_from_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lp_line_o == 2'b01) |-> ($past(lp_line_o) == 2'b11));

   // R4: high-speed starts from LP-00 with a zero byte
   p_hs_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_en_o) |-> ($past(lp_line_o) == 2'b00) && (hs_data_o == '0));

   // R5: bytes are taken only while driving high-speed
   p_ready_in_hs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tx_ready_o |-> hs_en_o);

   // R5: a payload cycle without valid repeats the previous byte
   p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_ready_o && !tx_valid_i && $past(tx_ready_o)) |-> $stable(hs_data_o));

   // R7: busy only drops out of the stop-level exit hold
   p_busy_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> ($past(lp_line_o) == 2'b11) && !$past(hs_en_o));

   // R11: any non-stop level implies busy
   p_busy_cover_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lp_line_o != 2'b11) |-> busy_o);

endmodule

bind dphy_lane_seq dphy_lane_seq_chk #(
   .FLD_W(FLD_W), .WORD_W(WORD_W), .DATA_W(DATA_W), .MSB_LAST(MSB_LAST)
) u_chk (.*);

// File: tb/dphy_lane_seq_tb.sv
`timescale 1ns/1ps
module dphy_lane_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [7:0]  tx_data = '0;
   logic        tx_valid = 1'b0;
   logic        tx_last = 1'b0;
   logic        tx_ready;
   logic [31:0] lane_t = '0;
   logic [31:0] gen_t = '0;
   logic [1:0]  lp;
   logic        hs_en;
   logic [7:0]  hs_data;
   logic        busy;

   int    n_chk = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   string tagx = "";

   always #10 clk = ~clk;

   dphy_lane_seq u_dut (
      .clk_i(clk), .rst_ni(rst_n), .burst_req_i(req),
      .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_last_i(tx_last),
      .tx_ready_o(tx_ready), .lane_timing_i(lane_t), .gen_timing_i(gen_t),
      .lp_line_o(lp), .hs_en_o(hs_en), .hs_data_o(hs_data), .busy_o(busy)
   );

   function automatic int fl(input logic [7:0] v);
      return (v == 8'd0) ? 1 : int'(v);
   endfunction

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tagx, what, act, exp);
      end
   endtask

   task automatic rand_cfg();
      lane_t = {8'($urandom), 8'($urandom_range(0, 10)), 8'($urandom_range(0, 10)),
                8'($urandom_range(0, 10))};
      gen_t  = {16'($urandom), 8'($urandom_range(0, 10)), 8'($urandom_range(0, 10))};
   endtask

   // runs one burst starting at an idle negedge, ends at the idle negedge after it
   task automatic burst(input bit do_req, input int n, input bit gaps,
                        input bit pulse, input bit mid);
      int e_lpx, e_prep, e_zero, e_trail, e_exit, c, i, guard;
      logic [7:0] d [8];
      logic [7:0] prev, expd, exp_t;
      bit zok, pok, tok, bok, gapped;
      int bad_act, bad_exp;
      e_lpx   = fl(gen_t[15:8]);
      e_exit  = fl(gen_t[7:0]);
      e_prep  = fl(lane_t[7:0]);
      e_zero  = fl(lane_t[15:8]);
      e_trail = fl(lane_t[23:16]);
      for (int k = 0; k < n; k++) d[k] = 8'($urandom);
      tx_data = d[0]; tx_valid = 1'b1; tx_last = (n == 1);
      if (do_req) req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      bok = 1'b1;
      chk(lp == 2'b01 && !hs_en, "R2 LP-01 entered after stop", lp, 1);
      c = 0;
      while (lp == 2'b01 && c < 600) begin if (!busy) bok = 0; c++; @(negedge clk); end
      chk(c == e_lpx, "R3 R8 LP-01 length", c, e_lpx);
      chk(lp == 2'b00 && !hs_en, "R2 LP-00 follows LP-01", lp, 0);
      c = 0;
      while (lp == 2'b00 && !hs_en && c < 600) begin if (!busy) bok = 0; c++; @(negedge clk); end
      chk(c == e_prep, "R4 R8 LP-00 length", c, e_prep);
      c = 0; zok = 1'b1;
      while (hs_en && !tx_ready && c < 600) begin
         if (hs_data != 8'h00 || lp != 2'b00) zok = 0;
         c++; @(negedge clk);
      end
      chk(c == e_zero, "R4 HS-0 length", c, e_zero);
      chk(zok, "R4 HS-0 drives zero bytes", zok, 1);
      i = 0; prev = 8'h00; gapped = 1'b0; pok = 1'b1; guard = 0;
      bad_act = 0; bad_exp = 0;
      while (i < n && guard < 100) begin
         req = (pulse && guard == 0);
         if (mid && guard == 0) rand_cfg();
         if (gaps && !gapped && ($urandom_range(0, 1) == 1)) begin
            tx_valid = 1'b0; gapped = 1'b1; expd = prev;
         end else begin
            tx_valid = 1'b1; tx_data = d[i]; tx_last = (i == n - 1);
            expd = d[i]; gapped = 1'b0;
         end
         #1;
         if ((!tx_ready || hs_data != expd) && pok) begin
            pok = 0; bad_act = hs_data; bad_exp = expd;
         end
         if (!busy) bok = 0;
         if (tx_valid) begin prev = d[i]; i++; end
         guard++;
         @(negedge clk);
      end
      req = 1'b0; tx_valid = 1'b0; tx_last = 1'b0;
      chk(pok, "R5 payload bytes on serializer", bad_act, bad_exp);
      exp_t = {8{~d[n-1][7]}};
      c = 0; tok = 1'b1;
      while (hs_en && c < 600) begin
         if (hs_data != exp_t || tx_ready) tok = 0;
         if (!busy) bok = 0;
         c++; @(negedge clk);
      end
      chk(c == e_trail, mid ? "R9 R6 trail length from old config" : "R6 trail length",
          c, e_trail);
      chk(tok, "R6 trail pattern inverts final bit", hs_data, exp_t);
      c = 0;
      while (lp == 2'b11 && busy && c < 600) begin c++; @(negedge clk); end
      chk(c == e_exit, mid ? "R9 R7 exit hold from old config" : "R7 R8 exit hold length",
          c, e_exit);
      chk(bok, "R11 busy held through burst", bok, 1);
      chk(!busy && lp == 2'b11 && !hs_en, "R11 R7 idle after exit hold", busy, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R2 watchdog expired actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C1A));
      lane_t = {8'h00, 8'd4, 8'd6, 8'd3};
      gen_t  = {16'h0000, 8'd3, 8'd5};
      repeat (3) @(negedge clk);
      chk(lp == 2'b11 && !hs_en && !busy && !tx_ready, "R1 stop state in reset", lp, 3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(lp == 2'b11 && !hs_en && !busy && !tx_ready, "R1 stop state after reset", lp, 3);

      tagx = "R2 first burst";
      burst(1'b1, 3, 1'b0, 1'b0, 1'b0);

      tagx = "R8 zero fields";
      lane_t = '0; gen_t = '0;
      burst(1'b1, 2, 1'b0, 1'b0, 1'b0);

      tagx = "R10 upper bits";
      lane_t = 32'hFF03_0201; gen_t = 32'hABCD_0204;
      burst(1'b1, 1, 1'b0, 1'b0, 1'b0);

      tagx = "R9 mid-burst rewrite";
      lane_t = 32'h0002_0302; gen_t = 32'h0000_0106;
      burst(1'b1, 4, 1'b0, 1'b0, 1'b1);
      tagx = "R9 new config applies";
      burst(1'b1, 2, 1'b0, 1'b0, 1'b0);

      tagx = "R11 queued request";
      burst(1'b1, 3, 1'b0, 1'b1, 1'b0);
      burst(1'b0, 2, 1'b0, 1'b0, 1'b0);

      tagx = "R5 stalled payload";
      burst(1'b1, 6, 1'b1, 1'b0, 1'b0);

      tagx = "random";
      for (int r = 0; r < 30; r++) begin
         rand_cfg();
         burst(1'b1, $urandom_range(1, 6), 1'($urandom_range(0, 1)), 1'b0, 1'b0);
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule